// File: doc/BRIEF.md
# Power Area Switch Controller

This block is a register-mapped controller that turns power areas off and on at software's request and reports when each switch has finished. Software reaches it over a plain 32-bit register port: one address, write and read strobes, write data, and read data that appears in the cycle after a read. A group of common registers reports whether the controller can take a new request and holds the completion status, its write-one-to-clear port, the per-area completion enable and the per-area interrupt mask. Areas are grouped into channels. Each channel has its own address window, with control, status and error registers in which every area of the channel owns one bit.

Software starts a switch by writing a one-hot word into a channel's shutoff or resume control register. The controller then runs a four-phase request/acknowledge handshake with the power switch of that area. When the handshake is done and the area's completion enable is set, the controller records the new state and raises the area's completion status. Only one transition is in flight at a time. A request that arrives while one is running is refused and noted in the channel's error register, and software retries it.

Top module: `pdc_top`

## Requirements
- R1: After reset, ready status (0x00) reads 3, completion status, enable and mask read 0, every power status bit reads 1 (area off, default), pwr_req_o is 0 and irq_o is 0.
- R2: A write of a one-hot value to a channel window's resume control (+0x0C) or shutoff control (+0x04) selects area channel*BITS_PER_CH+bit. Ready status reads 0 until it finishes. The area's pwr_req_o bit is raised with pwr_dir_o (1 = resume, 0 = shutoff) and is held until the matching pwr_ack_i bit is high. It then drops, and the controller waits for the acknowledge to fall.
- R3: A request written while a transition is in flight starts no handshake. It sets the area's bit in the channel's error register (+0x14). An accepted request for that area clears the bit.
- R4: A control write whose value is not one-hot, or whose set bit is not below BITS_PER_CH, starts nothing: ready stays 3 and no request is raised.
- R5: A transition only completes while the area's enable bit (0x0C) is set. Until then ready stays 0 and the completion status bit stays 0.
- R6: The mask register (0x10) only gates irq_o. A masked area still completes and sets its status bit.
- R7: Writing 1 to a bit of the clear register (0x08) clears that completion status bit. If a completion sets the same bit in the same cycle, the set wins.
- R8: In the power status register (+0x00), a 1 means the area is off. The bit changes only when a transition completes.
- R9: A request whose target state equals the area's current state raises no handshake and completes one cycle later, still setting its completion status bit.
- R10: irq_o is a registered OR of the completion status bits that are enabled and not masked.
- R11: While a transition is in flight, its area's channel bit reads 1 in the shutoff status (+0x08) or resume status (+0x10) register, whichever matches its direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| pwr_req_o | output | N_AREA | Per-area switch request |
| pwr_dir_o | output | 1 | Direction of the active request, 1 = power on |
| pwr_ack_i | input | N_AREA | Per-area switch acknowledge |
| irq_o | output | 1 | Completion interrupt |

## Verification
Two events can fall in the same cycle: a transition completing and setting its status bit, and software writing one to that same bit of the clear register. The bench provokes this by holding a transition at its final stage with its enable bit clear. It then writes the enable and the clear back to back, so the completion lands on the very edge that captures the clear. The status must read 1 afterwards. A second collision checked is a request written on the edge right after another was accepted: it must land in the error register and leave the running handshake alone.

// File: rtl/pdc_pkg.sv
package pdc_pkg;
  // common register offsets
  localparam int unsigned OFS_READY = 'h00;
  localparam int unsigned OFS_DONE  = 'h04;
  localparam int unsigned OFS_CLEAR = 'h08;
  localparam int unsigned OFS_ENAB  = 'h0C;
  localparam int unsigned OFS_MASK  = 'h10;
  // per-channel window offsets
  localparam int unsigned WIN_STATE  = 'h00;
  localparam int unsigned WIN_DOWN   = 'h04;
  localparam int unsigned WIN_DOWNSR = 'h08;
  localparam int unsigned WIN_UP     = 'h0C;
  localparam int unsigned WIN_UPSR   = 'h10;
  localparam int unsigned WIN_ERR    = 'h14;

  typedef enum logic [1:0] {SQ_IDLE, SQ_REQ, SQ_REL, SQ_FIN} seq_state_e;
endpackage

// File: rtl/pdc_decode.sv
module pdc_decode #(
  parameter int ADDR_W      = 8,
  parameter int CH_COUNT    = 2,
  parameter int BITS_PER_CH = 2,
  parameter int WIN_BASE    = 32,
  parameter int WIN_SHIFT   = 5,
  localparam int N_AREA = CH_COUNT * BITS_PER_CH,
  localparam int AW     = (N_AREA > 1) ? $clog2(N_AREA) : 1,
  localparam int CW     = (CH_COUNT > 1) ? $clog2(CH_COUNT) : 1
) (
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 wr,
  input  logic [31:0]          wdata,
  output logic                 win_hit,
  output logic [CW-1:0]        win_ch,
  output logic [WIN_SHIFT-1:0] win_off,
  output logic                 req_valid,
  output logic [AW-1:0]        req_area,
  output logic                 req_dir
);
  import pdc_pkg::*;

  logic [ADDR_W-1:0] rel;
  logic [ADDR_W-1:0] ch_full;
  logic              is_ctl;
  logic              one_hot;
  int                bit_idx;

  always_comb begin
    rel     = addr - ADDR_W'(WIN_BASE);
    ch_full = rel >> WIN_SHIFT;
    win_hit = (addr >= ADDR_W'(WIN_BASE)) && (int'(ch_full) < CH_COUNT);
    win_ch  = CW'(ch_full);
    win_off = addr[WIN_SHIFT-1:0];
  end

  always_comb begin
    bit_idx = 0;
    for (int b = 0; b < BITS_PER_CH; b++)
      if (wdata[b]) bit_idx = b;
    one_hot = $onehot(wdata[BITS_PER_CH-1:0]) && (wdata[31:BITS_PER_CH] == '0);
    is_ctl  = (int'(win_off) == WIN_DOWN) || (int'(win_off) == WIN_UP);
    req_valid = wr && win_hit && is_ctl && one_hot;
    req_dir   = (int'(win_off) == WIN_UP);
    req_area  = AW'(int'(win_ch) * BITS_PER_CH + bit_idx);
  end
endmodule

// File: rtl/pdc_seq.sv
module pdc_seq #(
  parameter int   N_AREA    = 4,
  parameter logic RESET_OFF = 1'b1,
  localparam int AW = (N_AREA > 1) ? $clog2(N_AREA) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [AW-1:0]     start_area,
  input  logic              start_dir,
  input  logic [N_AREA-1:0] enab,
  input  logic [N_AREA-1:0] ack_i,
  output logic              busy,
  output logic [N_AREA-1:0] req_o,
  output logic              dir_o,
  output logic [N_AREA-1:0] flight_vec,
  output logic [N_AREA-1:0] done_vec,
  output logic [N_AREA-1:0] off_state
);
  import pdc_pkg::*;

  seq_state_e    state;
  logic [AW-1:0] area_q;
  logic          finish;

  assign busy   = (state != SQ_IDLE);
  assign finish = (state == SQ_FIN) && enab[area_q];

  always_comb begin
    done_vec   = '0;
    flight_vec = '0;
    if (finish) done_vec[area_q] = 1'b1;
    if (busy)   flight_vec[area_q] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= SQ_IDLE;
      area_q    <= '0;
      dir_o     <= 1'b0;
      req_o     <= '0;
      off_state <= {N_AREA{RESET_OFF}};
    end else begin
      case (state)
        SQ_IDLE: if (start) begin
          area_q <= start_area;
          dir_o  <= start_dir;
          if (off_state[start_area] != start_dir) begin
            state <= SQ_FIN;
          end else begin
            state             <= SQ_REQ;
            req_o[start_area] <= 1'b1;
          end
        end
        SQ_REQ: if (ack_i[area_q]) begin
          req_o <= '0;
          state <= SQ_REL;
        end
        SQ_REL: if (!ack_i[area_q]) state <= SQ_FIN;
        SQ_FIN: if (finish) begin
          off_state[area_q] <= !dir_o;
          state             <= SQ_IDLE;
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pdc_irq.sv
module pdc_irq #(
  parameter int N_AREA = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_clear,
  input  logic              wr_enab,
  input  logic              wr_mask,
  input  logic [N_AREA-1:0] wdata,
  input  logic [N_AREA-1:0] set_vec,
  output logic [N_AREA-1:0] done_st,
  output logic [N_AREA-1:0] enab,
  output logic [N_AREA-1:0] mask,
  output logic              irq_o
);
  logic [N_AREA-1:0] clr_vec;

  assign clr_vec = wr_clear ? wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      done_st <= '0;
      enab    <= '0;
      mask    <= '0;
      irq_o   <= 1'b0;
    end else begin
      done_st <= (done_st & ~clr_vec) | set_vec;
      if (wr_enab) enab <= wdata;
      if (wr_mask) mask <= wdata;
      irq_o <= |(done_st & enab & ~mask);
    end
  end
endmodule

// File: rtl/pdc_top.sv
module pdc_top #(
  parameter int   ADDR_W      = 8,
  parameter int   CH_COUNT    = 2,
  parameter int   BITS_PER_CH = 2,
  parameter int   WIN_BASE    = 32,
  parameter int   WIN_SHIFT   = 5,
  parameter logic RESET_OFF   = 1'b1,
  localparam int N_AREA = CH_COUNT * BITS_PER_CH,
  localparam int AW     = (N_AREA > 1) ? $clog2(N_AREA) : 1,
  localparam int CW     = (CH_COUNT > 1) ? $clog2(CH_COUNT) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [N_AREA-1:0] pwr_req_o,
  output logic              pwr_dir_o,
  input  logic [N_AREA-1:0] pwr_ack_i,
  output logic              irq_o
);
  import pdc_pkg::*;

  logic                 win_hit, req_valid, req_dir;
  logic [CW-1:0]        win_ch;
  logic [WIN_SHIFT-1:0] win_off;
  logic [AW-1:0]        req_area;
  logic                 busy, accept, refuse;
  logic [N_AREA-1:0]    flight_vec, done_vec, pstat;
  logic [N_AREA-1:0]    isr_q, ier_q, imr_q, err_q;
  logic                 wr_common;
  logic [31:0]          rd_mux;

  pdc_decode #(
    .ADDR_W(ADDR_W), .CH_COUNT(CH_COUNT), .BITS_PER_CH(BITS_PER_CH),
    .WIN_BASE(WIN_BASE), .WIN_SHIFT(WIN_SHIFT)
  ) u_dec (
    .addr(bus_addr), .wr(bus_wr), .wdata(bus_wdata),
    .win_hit(win_hit), .win_ch(win_ch), .win_off(win_off),
    .req_valid(req_valid), .req_area(req_area), .req_dir(req_dir)
  );

  assign accept = req_valid && !busy;
  assign refuse = req_valid && busy;

  pdc_seq #(.N_AREA(N_AREA), .RESET_OFF(RESET_OFF)) u_seq (
    .clk(clk), .rst(rst),
    .start(accept), .start_area(req_area), .start_dir(req_dir),
    .enab(ier_q), .ack_i(pwr_ack_i),
    .busy(busy), .req_o(pwr_req_o), .dir_o(pwr_dir_o),
    .flight_vec(flight_vec), .done_vec(done_vec), .off_state(pstat)
  );

  assign wr_common = bus_wr && !win_hit;

  pdc_irq #(.N_AREA(N_AREA)) u_irq (
    .clk(clk), .rst(rst),
    .wr_clear(wr_common && (int'(bus_addr) == OFS_CLEAR)),
    .wr_enab (wr_common && (int'(bus_addr) == OFS_ENAB)),
    .wr_mask (wr_common && (int'(bus_addr) == OFS_MASK)),
    .wdata(bus_wdata[N_AREA-1:0]), .set_vec(done_vec),
    .done_st(isr_q), .enab(ier_q), .mask(imr_q), .irq_o(irq_o)
  );

  // refusal record, one bit per area
  always_ff @(posedge clk) begin
    if (rst) err_q <= '0;
    else if (refuse) err_q[req_area] <= 1'b1;
    else if (accept) err_q[req_area] <= 1'b0;
  end

  function automatic logic [31:0] ch_slice(input logic [N_AREA-1:0] v, input logic [CW-1:0] ch);
    logic [BITS_PER_CH-1:0] s;
    s = v[int'(ch)*BITS_PER_CH +: BITS_PER_CH];
    return 32'(s);
  endfunction

  always_comb begin
    rd_mux = '0;
    if (win_hit) begin
      case (int'(win_off))
        WIN_STATE:  rd_mux = ch_slice(pstat, win_ch);
        WIN_DOWNSR: rd_mux = pwr_dir_o ? '0 : ch_slice(flight_vec, win_ch);
        WIN_UPSR:   rd_mux = pwr_dir_o ? ch_slice(flight_vec, win_ch) : '0;
        WIN_ERR:    rd_mux = ch_slice(err_q, win_ch);
        default:    rd_mux = '0;
      endcase
    end else begin
      case (int'(bus_addr))
        OFS_READY: rd_mux = busy ? 32'd0 : 32'd3;
        OFS_DONE:  rd_mux = 32'(isr_q);
        OFS_ENAB:  rd_mux = 32'(ier_q);
        OFS_MASK:  rd_mux = 32'(imr_q);
        default:   rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/pdc_chk.sv
module pdc_chk #(
  parameter int N_AREA = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic [N_AREA-1:0] pwr_req_o,
  input logic              pwr_dir_o,
  input logic [N_AREA-1:0] pwr_ack_i,
  input logic [N_AREA-1:0] isr,
  input logic [N_AREA-1:0] ier,
  input logic [N_AREA-1:0] imr,
  input logic [N_AREA-1:0] pstat,
  input logic              irq_o
);
  AST_REQ_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(pwr_req_o)); // R2
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    (|(pwr_req_o & ~pwr_ack_i)) |=> ($stable(pwr_req_o) && $stable(pwr_dir_o))); // R2
  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (pwr_req_o == '0)); // R2
  AST_SET_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    ((isr & ~$past(isr) & ~$past(ier)) == '0)); // R5
  AST_MASK_QUIET: assert property (@(posedge clk) disable iff (rst)
    ((isr & ier & ~imr) == '0) |=> !irq_o); // R6
  AST_STATE_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
    !busy |=> $stable(pstat)); // R8
endmodule

bind pdc_top pdc_chk #(.N_AREA(N_AREA)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .pwr_req_o(pwr_req_o),
  .pwr_dir_o(pwr_dir_o), .pwr_ack_i(pwr_ack_i), .isr(isr_q), .ier(ier_q),
  .imr(imr_q), .pstat(pstat), .irq_o(irq_o)
);

// File: tb/pdc_top_bench.sv
module pdc_top_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  pwr_req_o;
  logic        pwr_dir_o;
  logic [3:0]  pwr_ack_i;
  logic        irq_o;
  logic [3:0]  req_d;
  int          n_chk = 0;
  int          n_bad = 0;
  logic [31:0] rv;

  always #10 clk = ~clk;

  pdc_top u_pdc_top (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwr_req_o(pwr_req_o),
    .pwr_dir_o(pwr_dir_o), .pwr_ack_i(pwr_ack_i), .irq_o(irq_o)
  );

  // behavioural switch: acknowledge trails request by two cycles
  always_ff @(posedge clk) begin
    if (rst) begin
      req_d <= '0; pwr_ack_i <= '0;
    end else begin
      req_d <= pwr_req_o; pwr_ack_i <= req_d;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic bwrite(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bread(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic expect_reg(input logic [7:0] a, input logic [31:0] e, input string tag);
    logic [31:0] d;
    bread(a, d);
    check(d == e, tag, d, e);
  endtask

  task automatic wait_idle(input string tag);
    logic [31:0] d;
    d = 0;
    for (int i = 0; i < 200; i++) begin
      bread('h00, d);
      if (d == 3) break;
    end
    check(d == 3, tag, d, 3);
  endtask

  task automatic t_reset;
    expect_reg('h00, 3, "R1 ready");
    expect_reg('h04, 0, "R1 status");
    expect_reg('h0C, 0, "R1 enable");
    expect_reg('h20, 3, "R1 R8 ch0 off");
    expect_reg('h40, 3, "R1 ch1 off");
    check(pwr_req_o == 0 && irq_o == 0, "R1 outputs", {pwr_req_o, 3'b0, irq_o}, 0);
  endtask

  task automatic t_power_on;
    bwrite('h2C, 1);
    check(pwr_req_o == 4'b0001 && pwr_dir_o, "R2 request", {pwr_dir_o, pwr_req_o}, 5'h11);
    expect_reg('h00, 0, "R2 not ready");
    expect_reg('h30, 1, "R11 resume status");
    expect_reg('h28, 0, "R11 shutoff status");
    wait_idle("R2 completes");
    expect_reg('h04, 1, "R6 masked done set");
    check(irq_o == 0, "R6 masked irq", irq_o, 0);
    expect_reg('h20, 2, "R8 area0 on");
    bwrite('h10, 'hE);
    repeat (2) @(negedge clk);
    check(irq_o == 1, "R10 irq", irq_o, 1);
    bwrite('h08, 1);
    repeat (2) @(negedge clk);
    check(irq_o == 0, "R10 irq drop", irq_o, 0);
    expect_reg('h04, 0, "R7 cleared");
    bwrite('h10, 'hF);
  endtask

  task automatic t_power_off;
    bwrite('h24, 1);
    check(pwr_req_o == 4'b0001 && !pwr_dir_o, "R2 shutoff req", {pwr_dir_o, pwr_req_o}, 5'h01);
    expect_reg('h28, 1, "R11 shutoff status");
    wait_idle("R2 shutoff done");
    expect_reg('h20, 3, "R8 area0 off");
    bwrite('h08, 'hF);
  endtask

  task automatic t_refuse;
    bwrite('h2C, 2);
    bwrite('h4C, 1);
    check(pwr_req_o == 4'b0010, "R3 no second handshake", pwr_req_o, 4'b0010);
    expect_reg('h54, 1, "R3 error set");
    expect_reg('h34, 0, "R3 other channel clean");
    wait_idle("R3 first done");
    bwrite('h4C, 1);
    expect_reg('h54, 0, "R3 error cleared");
    wait_idle("R3 retry done");
    expect_reg('h40, 2, "R8 area2 on");
    expect_reg('h20, 1, "R8 area1 on");
    expect_reg('h04, 6, "R3 both done");
    bwrite('h08, 'hF);
  endtask

  task automatic t_ignore;
    bwrite('h2C, 3);
    expect_reg('h00, 3, "R4 multi-hot ignored");
    bwrite('h2C, 4);
    expect_reg('h00, 3, "R4 high bit ignored");
    check(pwr_req_o == 0, "R4 no request", pwr_req_o, 0);
    expect_reg('h20, 1, "R4 state kept");
  endtask

  task automatic t_same_state;
    bwrite('h2C, 2);
    check(pwr_req_o == 0, "R9 no handshake", pwr_req_o, 0);
    wait_idle("R9 completes");
    expect_reg('h04, 2, "R9 status set");
    bwrite('h08, 'hF);
  endtask

  task automatic t_enable_gate;
    bwrite('h4C, 2);
    repeat (30) @(negedge clk);
    expect_reg('h00, 0, "R5 held");
    expect_reg('h04, 0, "R5 no status");
    expect_reg('h40, 2, "R5 state unchanged");
    bwrite('h0C, 'hF);
    bwrite('h08, 'h8);
    expect_reg('h04, 8, "R7 set wins");
    expect_reg('h00, 3, "R5 released");
    expect_reg('h40, 0, "R8 area3 on");
    bwrite('h08, 'h8);
    expect_reg('h04, 0, "R7 clear after");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset;
    bwrite('h0C, 'h7);
    bwrite('h10, 'hF);
    t_power_on;
    t_power_off;
    t_refuse;
    t_ignore;
    t_same_state;
    t_enable_gate;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule